// File: doc/BRIEF.md
# Two-Team Keypad Score Controller

This block keeps score for a game between two teams, yellow and red. A level switch opens and closes the game. Points come in as two-key keypad sequences: a team key (star for yellow, hash for red) followed by a digit key of 1, 2 or 3. Each team's total is held as packed BCD. The yellow total feeds the leftmost display digits and the red total feeds the rightmost ones. Keypad scanning, debouncing and seven-segment multiplexing are done upstream and downstream of this block. It takes one-cycle key strobes that carry a 4-bit key code.

While a game runs, a team's LED lights once that team scores. When the switch drops, the block compares the totals and blinks only the leader's LED at the configured rate, which is 4 Hz from a 50 MHz clock by default. A tie leaves both LEDs dark. The final totals stay on the outputs until the next game starts.

Top module: `score_keeper_top`

## Requirements
- R1: During reset and after it, both totals read 00 and both LEDs are off, with no game running.
- R2: At the first clock edge that samples the switch high after it was low, both totals clear to 00, both LEDs go off and any pending team key is dropped. A key strobe at that same edge is ignored.
- R3: Key codes are 4'hA = star (yellow), 4'hB = hash (red) and 4'h0..4'h9 = digits. A team key followed by digit 1, 2 or 3 adds that many points to the team at the clock edge of the digit strobe. Each total is packed BCD with tens in bits [7:4] and units in bits [3:0], and every nibble stays in 0..9.
- R4: While the game runs, a team's LED turns on at the edge that adds its points and stays on until the game ends.
- R5: A team key followed by any code other than 1, 2 or 3 (including 0, 4..9 and 4'hC..4'hF) cancels the sequence with no score change. A digit with no pending team key has no effect. A second team key replaces the pending one.
- R6: A total that would pass 99 saturates at 99.
- R7: While the switch is low, key strobes are ignored and both totals hold their values.
- R8: At the first edge that samples the switch low after a game, both LEDs go off. The leader's LED then turns on HALF = CLK_HZ/(2*BLINK_HZ) edges later and toggles every HALF edges after that. The other LED stays off.
- R9: If the totals are equal when the game is over, both LEDs stay off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| game_sw | input | 1 | Game switch level: high runs a game, low ends it |
| key_vld | input | 1 | One-cycle strobe marking a valid key code |
| key_code | input | 4 | Key code: 0-9 digits, A star, B hash |
| yel_bcd | output | 4*DIGITS | Yellow total, packed BCD |
| red_bcd | output | 4*DIGITS | Red total, packed BCD |
| yel_led | output | 1 | Yellow team LED |
| red_led | output | 1 | Red team LED |

## Verification
Totals and in-game LEDs change at the same edge that captures the digit strobe, switch rise or switch fall. The bench therefore drives inputs on falling edges and compares each output on the falling edge that follows the capturing rising edge. The end-of-game blink is due HALF edges after the closing edge, so directed checks sample at HALF and HALF+1 falling edges after the switch drops, to catch an early or late toggle. A behavioural model advances with the rising edge and is compared against every output on every falling edge, so that cancelled sequences, saturation and ignored keys are caught in the cycle where they would go wrong.

// File: rtl/score_pkg.sv
package score_pkg;

   localparam int unsigned NTEAMS   = 2;
   localparam int unsigned TEAM_YEL = 0;
   localparam int unsigned TEAM_RED = 1;

   localparam logic [3:0] KEY_STAR = 4'hA;
   localparam logic [3:0] KEY_HASH = 4'hB;

   typedef enum logic [1:0] {
      PEND_NONE = 2'd0,
      PEND_YEL  = 2'd1,
      PEND_RED  = 2'd2
   } pend_e;

endpackage

// File: rtl/score_key_decoder.sv
module score_key_decoder
   import score_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       accept,
   input  logic [3:0] code,
   output logic       add_vld,
   output logic       add_red,
   output logic [1:0] add_pts
);

   pend_e pend_q;
   logic  is_pts;

   assign is_pts  = (code >= 4'd1) && (code <= 4'd3);
   assign add_vld = accept && is_pts && (pend_q != PEND_NONE);
   assign add_red = (pend_q == PEND_RED);
   assign add_pts = code[1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= PEND_NONE;
      end else if (clr) begin
         pend_q <= PEND_NONE;
      end else if (accept) begin
         if (code == KEY_STAR)      pend_q <= PEND_YEL;
         else if (code == KEY_HASH) pend_q <= PEND_RED;
         else                       pend_q <= PEND_NONE;
      end
   end

endmodule

// File: rtl/score_bcd_counter.sv
module score_bcd_counter #(
   parameter int unsigned DIGITS   = 2,
   parameter bit          SATURATE = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr,
   input  logic                  add_vld,
   input  logic [1:0]            add_pts,
   output logic [4*DIGITS-1:0]   score
);

   localparam int unsigned SW = 4 * DIGITS;
   localparam logic [SW-1:0] ALL_NINES = {DIGITS{4'h9}};

   logic [SW-1:0] score_q;
   logic [SW-1:0] raw_sum;
   logic [SW-1:0] next_sum;
   logic [1:0]    inc [DIGITS+1];

   assign inc[0] = add_pts;

   for (genvar d = 0; d < DIGITS; d++) begin : g_digit
      logic [4:0] sum;
      logic [4:0] less_ten;
      assign sum      = {1'b0, score_q[4*d +: 4]} + {3'b000, inc[d]};
      assign less_ten = sum - 5'd10;
      assign raw_sum[4*d +: 4] = (sum > 5'd9) ? less_ten[3:0] : sum[3:0];
      assign inc[d+1] = {1'b0, (sum > 5'd9)};
   end

   if (SATURATE) begin : g_sat
      assign next_sum = (inc[DIGITS] != 2'd0) ? ALL_NINES : raw_sum;
   end else begin : g_wrap
      assign next_sum = raw_sum;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       score_q <= '0;
      else if (clr)     score_q <= '0;
      else if (add_vld) score_q <= next_sum;
   end

   assign score = score_q;

endmodule

// File: rtl/score_blink.sv
module score_blink #(
   parameter int unsigned HALF = 6_250_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold,
   output logic phase
);

   logic phase_q;

   if (HALF <= 1) begin : g_fast
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    phase_q <= 1'b0;
         else if (hold) phase_q <= 1'b0;
         else           phase_q <= ~phase_q;
      end
   end else begin : g_count
      localparam int unsigned CW = $clog2(HALF);
      localparam logic [CW-1:0] LAST = CW'(HALF - 1);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
         end else if (hold) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
         end else if (cnt_q == LAST) begin
            cnt_q   <= '0;
            phase_q <= ~phase_q;
         end else begin
            cnt_q   <= cnt_q + 1'b1;
         end
      end
   end

   assign phase = phase_q;

endmodule

// File: rtl/score_keeper_top.sv
module score_keeper_top
   import score_pkg::*;
#(
   parameter int unsigned CLK_HZ   = 50_000_000,
   parameter int unsigned BLINK_HZ = 4,
   parameter int unsigned DIGITS   = 2,
   parameter bit          SATURATE = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                game_sw,
   input  logic                key_vld,
   input  logic [3:0]          key_code,
   output logic [4*DIGITS-1:0] yel_bcd,
   output logic [4*DIGITS-1:0] red_bcd,
   output logic                yel_led,
   output logic                red_led
);

   localparam int unsigned SW   = 4 * DIGITS;
   localparam int unsigned HALF = CLK_HZ / (2 * BLINK_HZ);

   initial begin
      if (DIGITS < 1)
         $fatal(1, "score_keeper_top: DIGITS must be at least 1");
      if (HALF < 1)
         $fatal(1, "score_keeper_top: CLK_HZ too low for BLINK_HZ");
   end

   logic              sw_q;
   logic              start_evt;
   logic              accept;
   logic              add_vld;
   logic              add_red;
   logic [1:0]        add_pts;
   logic              phase;
   logic [SW-1:0]     score [NTEAMS];
   logic [NTEAMS-1:0] lit_q;

   assign start_evt = game_sw && !sw_q;
   assign accept    = key_vld && sw_q && game_sw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sw_q <= 1'b0;
      else        sw_q <= game_sw;
   end

   score_key_decoder u_dec (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (start_evt),
      .accept  (accept),
      .code    (key_code),
      .add_vld (add_vld),
      .add_red (add_red),
      .add_pts (add_pts)
   );

   for (genvar t = 0; t < NTEAMS; t++) begin : g_team
      localparam bit IS_RED = (t == TEAM_RED);
      logic hit;
      assign hit = add_vld && (add_red == IS_RED);

      score_bcd_counter #(
         .DIGITS   (DIGITS),
         .SATURATE (SATURATE)
      ) u_cnt (
         .clk     (clk),
         .rst_n   (rst_n),
         .clr     (start_evt),
         .add_vld (hit),
         .add_pts (add_pts),
         .score   (score[t])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         lit_q[t] <= 1'b0;
         else if (start_evt) lit_q[t] <= 1'b0;
         else if (hit)       lit_q[t] <= 1'b1;
      end
   end

   score_blink #(.HALF(HALF)) u_blink (
      .clk   (clk),
      .rst_n (rst_n),
      .hold  (sw_q),
      .phase (phase)
   );

   assign yel_bcd = score[TEAM_YEL];
   assign red_bcd = score[TEAM_RED];
   assign yel_led = sw_q ? lit_q[TEAM_YEL]
                         : (phase && (score[TEAM_YEL] > score[TEAM_RED]));
   assign red_led = sw_q ? lit_q[TEAM_RED]
                         : (phase && (score[TEAM_RED] > score[TEAM_YEL]));

endmodule

// File: rtl/score_keeper_chk.sv
module score_keeper_chk #(
   parameter int unsigned DIGITS = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic                game_sw,
   input logic [4*DIGITS-1:0] yel_bcd,
   input logic [4*DIGITS-1:0] red_bcd,
   input logic                yel_led,
   input logic                red_led
);

   localparam logic [4*DIGITS-1:0] ALL_NINES = {DIGITS{4'h9}};

   logic [1:0] age_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              age_q <= 2'd0;
      else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
   end

   function automatic int bcd_val(input logic [4*DIGITS-1:0] v);
      int acc = 0;
      for (int d = DIGITS - 1; d >= 0; d--) acc = acc * 10 + int'(v[4*d +: 4]);
      return acc;
   endfunction

   function automatic bit is_bcd(input logic [4*DIGITS-1:0] v);
      bit ok = 1'b1;
      for (int d = 0; d < DIGITS; d++) if (v[4*d +: 4] > 4'd9) ok = 1'b0;
      return ok;
   endfunction

   // R3
   bcd_digits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_bcd(yel_bcd) && is_bcd(red_bcd));

   // R2
   start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q == 2'd3 && $past(game_sw) && !$past(game_sw, 2))
      |-> (yel_bcd == '0 && red_bcd == '0 && !yel_led && !red_led));

   // R3
   step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q == 2'd3 && $past(game_sw) && $past(game_sw, 2))
      |-> (bcd_val(yel_bcd) >= bcd_val($past(yel_bcd)) &&
           bcd_val(yel_bcd) <= bcd_val($past(yel_bcd)) + 3 &&
           bcd_val(red_bcd) >= bcd_val($past(red_bcd)) &&
           bcd_val(red_bcd) <= bcd_val($past(red_bcd)) + 3 &&
           ($stable(yel_bcd) || $stable(red_bcd))));

   // R6
   sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q == 2'd3 && $past(game_sw) && $past(game_sw, 2) &&
       $past(yel_bcd) == ALL_NINES) |-> (yel_bcd == ALL_NINES));

   // R7
   ended_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q == 2'd3 && !$past(game_sw) && !$past(game_sw, 2))
      |-> ($stable(yel_bcd) && $stable(red_bcd)));

   // R9
   tie_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q >= 2'd2 && !$past(game_sw) && yel_bcd == red_bcd)
      |-> (!yel_led && !red_led));

   // R8
   loser_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q >= 2'd2 && !$past(game_sw))
      |-> (!(yel_led && red_led) &&
           !(yel_led && yel_bcd < red_bcd) &&
           !(red_led && red_bcd < yel_bcd)));

endmodule

bind score_keeper_top score_keeper_chk #(.DIGITS(DIGITS)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .game_sw (game_sw),
   .yel_bcd (yel_bcd),
   .red_bcd (red_bcd),
   .yel_led (yel_led),
   .red_led (red_led)
);

// File: tb/score_keeper_top_tb.sv
module score_keeper_top_tb;

   localparam int CLK_HZ   = 160;
   localparam int BLINK_HZ = 4;
   localparam int HALF     = CLK_HZ / (2 * BLINK_HZ);

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       game_sw = 1'b0;
   logic       key_vld = 1'b0;
   logic [3:0] key_code = 4'h0;
   logic [7:0] yel_bcd, red_bcd;
   logic       yel_led, red_led;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   string cur_req = "R1";

   // behavioural reference state
   int m_sw = 0, m_y = 0, m_r = 0, m_pend = 0, m_ylit = 0, m_rlit = 0, m_end = 0;

   always #5 clk = ~clk;

   score_keeper_top #(.CLK_HZ(CLK_HZ), .BLINK_HZ(BLINK_HZ), .DIGITS(2), .SATURATE(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .game_sw(game_sw), .key_vld(key_vld), .key_code(key_code),
      .yel_bcd(yel_bcd), .red_bcd(red_bcd), .yel_led(yel_led), .red_led(red_led));

   function automatic logic [7:0] to_bcd(input int v);
      return 8'(((v / 10) << 4) | (v % 10));
   endfunction

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_sw = 0; m_y = 0; m_r = 0; m_pend = 0; m_ylit = 0; m_rlit = 0; m_end = 0;
      end else begin
         if (game_sw && m_sw == 0) begin
            m_y = 0; m_r = 0; m_pend = 0; m_ylit = 0; m_rlit = 0;
         end else if (key_vld && game_sw && m_sw == 1) begin
            if (key_code == 4'hA) m_pend = 1;
            else if (key_code == 4'hB) m_pend = 2;
            else begin
               if (key_code >= 1 && key_code <= 3 && m_pend == 1) begin
                  m_y = (m_y + key_code > 99) ? 99 : m_y + key_code; m_ylit = 1;
               end
               if (key_code >= 1 && key_code <= 3 && m_pend == 2) begin
                  m_r = (m_r + key_code > 99) ? 99 : m_r + key_code; m_rlit = 1;
               end
               m_pend = 0;
            end
         end
         m_end = (m_sw == 1) ? 0 : m_end + 1;
         m_sw  = game_sw ? 1 : 0;
      end
      if (cyc > 150000) begin
         fails++;
         $display("FAIL watchdog act=%0d exp=<150000", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         int ph;
         int ey, er;
         ph = (m_end / HALF) % 2;
         ey = m_sw ? m_ylit : ((ph == 1 && m_y > m_r) ? 1 : 0);
         er = m_sw ? m_rlit : ((ph == 1 && m_r > m_y) ? 1 : 0);
         chk(yel_bcd == to_bcd(m_y), cur_req, "yel_bcd", yel_bcd, to_bcd(m_y));
         chk(red_bcd == to_bcd(m_r), cur_req, "red_bcd", red_bcd, to_bcd(m_r));
         chk(yel_led == ey[0], cur_req, "yel_led", yel_led, ey);
         chk(red_led == er[0], cur_req, "red_led", red_led, er);
      end
   end

   task automatic press(input logic [3:0] c);
      @(negedge clk); key_vld = 1'b1; key_code = c;
      @(negedge clk); key_vld = 1'b0; key_code = 4'h0;
   endtask

   task automatic end_game();
      @(negedge clk); game_sw = 1'b0;
   endtask

   initial begin
      // R1 reset state
      repeat (3) @(negedge clk);
      chk(yel_bcd == 8'h00 && red_bcd == 8'h00, "R1", "scores in reset", {yel_bcd, red_bcd}, 0);
      chk(!yel_led && !red_led, "R1", "leds in reset", {yel_led, red_led}, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R2 start, with a key at the start edge ignored
      cur_req = "R2";
      game_sw = 1'b1; key_vld = 1'b1; key_code = 4'hA;
      @(negedge clk); key_vld = 1'b0;
      press(4'h2);
      chk(yel_bcd == 8'h00, "R2", "key at start edge", yel_bcd, 8'h00);

      // R3 / R4 scoring
      cur_req = "R3";
      press(4'hA); press(4'h1);
      chk(yel_bcd == 8'h01, "R3", "star 1", yel_bcd, 8'h01);
      chk(yel_led && !red_led, "R4", "yellow lit only", {yel_led, red_led}, 2'b10);
      press(4'hA); press(4'h3);
      chk(yel_bcd == 8'h04, "R3", "star 3", yel_bcd, 8'h04);
      press(4'hB); press(4'h2);
      chk(red_bcd == 8'h02, "R3", "hash 2", red_bcd, 8'h02);
      chk(yel_led && red_led, "R4", "both lit", {yel_led, red_led}, 2'b11);

      // R5 cancelled and replaced sequences
      cur_req = "R5";
      press(4'hA); press(4'h5);
      press(4'hB); press(4'h0);
      press(4'h2);
      press(4'hA); press(4'hE); press(4'h1);
      chk(yel_bcd == 8'h04 && red_bcd == 8'h02, "R5", "discarded", {yel_bcd, red_bcd}, 16'h0402);
      press(4'hA); press(4'hB); press(4'h1);
      chk(red_bcd == 8'h03 && yel_bcd == 8'h04, "R5", "prefix replaced", {yel_bcd, red_bcd}, 16'h0403);
      @(negedge clk); key_vld = 1'b1; key_code = 4'hA;
      @(negedge clk); key_code = 4'h3;
      @(negedge clk); key_vld = 1'b0; key_code = 4'h0;
      chk(yel_bcd == 8'h07, "R3", "back-to-back strobes", yel_bcd, 8'h07);

      // R6 saturation
      cur_req = "R6";
      for (int i = 0; i < 31; i++) begin press(4'hA); press(4'h3); end
      chk(yel_bcd == 8'h99, "R6", "saturate", yel_bcd, 8'h99);
      press(4'hA); press(4'h1);
      chk(yel_bcd == 8'h99, "R6", "stay at 99", yel_bcd, 8'h99);

      // R8 yellow leads and blinks
      cur_req = "R8";
      end_game();
      @(negedge clk);
      chk(!yel_led && !red_led, "R8", "dark after end", {yel_led, red_led}, 0);
      repeat (HALF - 1) @(negedge clk);
      chk(!yel_led, "R8", "still off at HALF", yel_led, 0);
      @(negedge clk);
      chk(yel_led && !red_led, "R8", "on after HALF", {yel_led, red_led}, 2'b10);
      repeat (HALF) @(negedge clk);
      chk(!yel_led, "R8", "off after 2*HALF", yel_led, 0);

      // R7 keys ignored after end
      cur_req = "R7";
      press(4'hB); press(4'h3); press(4'hA); press(4'h1);
      repeat (5) @(negedge clk);
      chk(yel_bcd == 8'h99 && red_bcd == 8'h03, "R7", "held", {yel_bcd, red_bcd}, 16'h9903);

      // R2 restart, R8 red leads
      cur_req = "R2";
      @(negedge clk); game_sw = 1'b1;
      @(negedge clk);
      chk(yel_bcd == 8'h00 && red_bcd == 8'h00 && !yel_led && !red_led, "R2", "restart clear",
          {yel_bcd, red_bcd, yel_led, red_led}, 0);
      cur_req = "R8";
      press(4'hB); press(4'h3);
      end_game();
      repeat (HALF + 1) @(negedge clk);
      chk(red_led && !yel_led, "R8", "red blinks", {yel_led, red_led}, 2'b01);
      repeat (3 * HALF) @(negedge clk);

      // R9 tie
      cur_req = "R9";
      @(negedge clk); game_sw = 1'b1;
      @(negedge clk);
      press(4'hA); press(4'h2); press(4'hB); press(4'h2);
      end_game();
      repeat (HALF + 1) @(negedge clk);
      chk(!yel_led && !red_led, "R9", "tie dark", {yel_led, red_led}, 0);
      repeat (3 * HALF) @(negedge clk);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule